// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block collects up to `NUM_SRC` interrupt request lines, latches a rising edge on any of them into a pending bit, and drives one interrupt line to the processor. Each pending bit is masked by a per-source enable bit. The combined result is gated by a two-bit global gate, and both gate bits must be set before the processor line can assert. Software reaches the block over a simple 32-bit register port made of a word address, a write strobe, write data and combinational read data.

Enable bits can be replaced all at once, or changed one at a time through write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. Pending bits are cleared through a write-one-to-clear acknowledge register. A vector register returns the lowest index among the sources that are both pending and enabled. When no source qualifies, it returns a value of `NUM_SRC` one bits, which is always at least the source count, so software reads any value at or above that count as "nothing to serve".

Register map, by word address: 0 pending, 1 acknowledge, 2 enable, 3 enable-set, 4 enable-clear, 5 gate, 6 vector. Addresses 7 and above are unmapped.

Top module: `intr_hub`

## Requirements
- R1: After reset, pending, enable and gate are all zero, `cpu_irq` is low, and the vector register (address 6) reads as `NUM_SRC` one bits.
- R2: A 0-to-1 transition on `req_i[i]` sets pending bit i. The bit stays set after the request drops. A request that is held high does not set the bit again once it has been acknowledged.
- R3: Address 0 reads the raw pending bits in positions [NUM_SRC-1:0], whatever the enables are. Writes to address 0 change nothing.
- R4: Writing a mask to address 1 clears every pending bit whose mask bit is 1 and leaves the others unchanged. Writing all ones clears every pending bit. Address 1 reads as zero.
- R5: Writing address 2 replaces all enable bits with write data [NUM_SRC-1:0], so writing zero disables every source. Address 2 reads back the enable bits.
- R6: Writing a mask to address 3 sets the matching enable bits and leaves the other enable bits unchanged. Address 3 reads as zero.
- R7: Writing a mask to address 4 clears the matching enable bits and leaves the other enable bits unchanged. Address 4 reads as zero.
- R8: Address 5 holds a two-bit gate in bits [1:0] and reads it back. `cpu_irq` can be high only in the cycle after the gate holds 2'b11.
- R9: `cpu_irq` is registered. At each clock edge it takes the value OR(pending AND enable) AND (gate == 2'b11), computed from the state before that edge.
- R10: Address 6 reads the lowest index i for which pending[i] and enable[i] are both 1, zero-extended. When no index qualifies, it reads NUM_SRC one bits.
- R11: When a rising request edge and an acknowledge of the same bit happen in the same cycle, the pending bit stays set.
- R12: Addresses 7 and above read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Interrupt request lines, edge-captured |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cpu_irq | output | 1 | Registered interrupt line to the processor |

## Verification
A wrong pending or enable bit shows up at the ports within one cycle: the vector read points at the wrong index or returns all ones, and `cpu_irq` flips one edge later. A lost set or clear in the enable logic appears in the very next readback of address 2. A request edge that loses to an acknowledge shows as a missing pending bit in the next read of address 0. The bench models every register in plain integer terms and compares both read data and `cpu_irq` after every clock, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/intr_pkg.sv
package intr_pkg;

   localparam int unsigned BUS_W = 32;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      RA_PEND  = 3'd0,
      RA_ACK   = 3'd1,
      RA_EN    = 3'd2,
      RA_ENSET = 3'd3,
      RA_ENCLR = 3'd4,
      RA_GATE  = 3'd5,
      RA_VEC   = 3'd6
   } reg_sel_e;

   localparam logic [1:0] GATE_ON = 2'b11;

endpackage

// File: rtl/intr_capture.sv
module intr_capture #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               ack_stb,
   input  logic [NUM_SRC-1:0] ack_mask,
   output logic [NUM_SRC-1:0] pend_o
);

   logic [NUM_SRC-1:0] req_q;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] clr;

   assign clr = ack_stb ? ack_mask : '0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q[i]  <= 1'b0;
            pend_o[i] <= 1'b0;
         end else begin
            req_q[i]  <= req_i[i];
            pend_o[i] <= (pend_o[i] & ~clr[i]) | rise[i];
         end
      end
      assign rise[i] = req_i[i] & ~req_q[i];
   end

   // R4: acknowledged bits without a fresh edge are cleared
   a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> ((pend_o & $past(ack_mask & ~rise)) == '0));

   // R11: a fresh edge always leaves its bit set
   a_r11_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));

   // R2: without an acknowledge no pending bit is lost
   a_r2_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_stb |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

endmodule

// File: rtl/intr_enable.sv
module intr_enable #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_full,
   input  logic               wr_set,
   input  logic               wr_clr,
   input  logic               wr_gate,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic [1:0]         gate_i,
   output logic [NUM_SRC-1:0] en_o,
   output logic [1:0]         gate_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= '0;
         gate_o <= '0;
      end else begin
         if (wr_full)
            en_o <= mask_i;
         else if (wr_set)
            en_o <= en_o | mask_i;
         else if (wr_clr)
            en_o <= en_o & ~mask_i;
         if (wr_gate)
            gate_o <= gate_i;
      end
   end

   // R6: set mask raises its bits and leaves the rest alone
   a_r6_set_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && !wr_full) |=> (((en_o & $past(mask_i)) == $past(mask_i)) &&
                               ((en_o & ~$past(mask_i)) == ($past(en_o) & ~$past(mask_i)))));

   // R7: clear mask drops its bits and leaves the rest alone
   a_r7_clr_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !wr_full && !wr_set) |=> (((en_o & $past(mask_i)) == '0) &&
                               ((en_o & ~$past(mask_i)) == ($past(en_o) & ~$past(mask_i)))));

endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic [NUM_SRC-1:0] act_i,
   output logic [NUM_SRC-1:0] vec_o
);

   always_comb begin
      vec_o = '1;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (act_i[i])
            vec_o = NUM_SRC'(i);
      end
   end

endmodule

// File: rtl/intr_hub.sv
module intr_hub
   import intr_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               cpu_irq
);

   if (NUM_SRC < 1 || NUM_SRC > BUS_W) begin : g_bad_src
      $error("intr_hub: NUM_SRC must lie in 1..32");
   end
   if (ADDR_W < SEL_W) begin : g_bad_addr
      $error("intr_hub: ADDR_W must be at least 3");
   end

   logic               in_map;
   logic [SEL_W-1:0]   sel;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] en;
   logic [NUM_SRC-1:0] act;
   logic [NUM_SRC-1:0] vec;
   logic [1:0]         gate;
   logic               wr_ack, wr_full, wr_set, wr_clr, wr_gate;

   assign in_map = (bus_addr >> SEL_W) == '0;
   assign sel    = bus_addr[SEL_W-1:0];
   assign mask   = bus_wdata[NUM_SRC-1:0];

   if (NUM_SRC < BUS_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^bus_wdata[BUS_W-1:NUM_SRC];
   end

   assign wr_ack  = bus_we && in_map && (sel == RA_ACK);
   assign wr_full = bus_we && in_map && (sel == RA_EN);
   assign wr_set  = bus_we && in_map && (sel == RA_ENSET);
   assign wr_clr  = bus_we && in_map && (sel == RA_ENCLR);
   assign wr_gate = bus_we && in_map && (sel == RA_GATE);

   intr_capture #(.NUM_SRC(NUM_SRC)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .ack_stb  (wr_ack),
      .ack_mask (mask),
      .pend_o   (pend)
   );

   intr_enable #(.NUM_SRC(NUM_SRC)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_full (wr_full),
      .wr_set  (wr_set),
      .wr_clr  (wr_clr),
      .wr_gate (wr_gate),
      .mask_i  (mask),
      .gate_i  (bus_wdata[1:0]),
      .en_o    (en),
      .gate_o  (gate)
   );

   assign act = pend & en;

   intr_prio #(.NUM_SRC(NUM_SRC)) u_prio (
      .act_i (act),
      .vec_o (vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cpu_irq <= 1'b0;
      else
         cpu_irq <= (|act) && (gate == GATE_ON);
   end

   always_comb begin
      bus_rdata = '0;
      if (in_map) begin
         case (sel)
            RA_PEND: bus_rdata = BUS_W'(pend);
            RA_EN:   bus_rdata = BUS_W'(en);
            RA_GATE: bus_rdata = BUS_W'(gate);
            RA_VEC:  bus_rdata = BUS_W'(vec);
            default: bus_rdata = '0;
         endcase
      end
   end

   // R8: the line stays low after any cycle without the full gate
   a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (gate != GATE_ON) |=> !cpu_irq);

   // R9: nothing active means the line is low next cycle
   a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0) |=> !cpu_irq);

   // R10: empty selection yields the all-ones vector
   a_r10_none_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0) |-> (vec == '1));

   // R10: a reported index names an active source with none lower
   a_r10_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (act != '0) |-> (act[vec] && ((act & ((NUM_SRC'(1) << vec) - NUM_SRC'(1))) == '0)));

endmodule

// File: tb/sim_intr_hub.sv
`timescale 1ns/1ps
module sim_intr_hub;

   localparam int unsigned N  = 8;
   localparam int unsigned AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   int n_cmp  = 0;
   int n_fail = 0;

   // reference state
   logic [N-1:0] m_pend, m_en, m_prev;
   logic [1:0]   m_gate;
   logic         m_irq;

   always #2 clk = ~clk;

   intr_hub #(.NUM_SRC(N), .ADDR_W(AW)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req),
      .bus_addr  (addr),
      .bus_we    (we),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .cpu_irq   (irq)
   );

   function automatic logic [31:0] m_vec();
      for (int i = 0; i < N; i++)
         if (m_pend[i] && m_en[i]) return 32'(i);
      return 32'((64'd1 << N) - 64'd1);
   endfunction

   function automatic logic [31:0] m_read(input int a);
      case (a)
         0: return 32'(m_pend);
         2: return 32'(m_en);
         5: return 32'(m_gate);
         6: return m_vec();
         default: return 32'd0;
      endcase
   endfunction

   task automatic m_reset();
      m_pend = '0; m_en = '0; m_prev = '0; m_gate = '0; m_irq = 1'b0;
   endtask

   task automatic m_clock();
      logic [N-1:0] rise;
      logic [N-1:0] ackm;
      rise  = req & ~m_prev;
      m_irq = ((m_pend & m_en) != '0) && (m_gate == 2'b11);
      ackm  = (we && addr == 1) ? wdata[N-1:0] : '0;
      m_pend = (m_pend & ~ackm) | rise;
      if (we) begin
         case (int'(addr))
            2: m_en = wdata[N-1:0];
            3: m_en = m_en | wdata[N-1:0];
            4: m_en = m_en & ~wdata[N-1:0];
            5: m_gate = wdata[1:0];
            default: ;
         endcase
      end
      m_prev = req;
   endtask

   task automatic compare(input string tag);
      logic [31:0] exp_rd;
      exp_rd = m_read(int'(addr));
      n_cmp++;
      if (rdata !== exp_rd) begin
         n_fail++;
         $display("FAIL %s rdata at addr %0d: actual=%h expected=%h", tag, addr, rdata, exp_rd);
      end
      n_cmp++;
      if (irq !== m_irq) begin
         n_fail++;
         $display("FAIL %s cpu_irq: actual=%b expected=%b", tag, irq, m_irq);
      end
   endtask

   // drive at a falling edge, advance one clock, compare at the next falling edge
   task automatic step(input int a, input bit w, input logic [31:0] d,
                       input logic [N-1:0] r, input string tag);
      addr = AW'(a); we = w; wdata = d; req = r;
      @(posedge clk);
      m_clock();
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
      step(6, 0, 0, '0, "R1");        // vector all ones
      step(0, 0, 0, '0, "R1");
      step(2, 0, 0, '0, "R1");
      step(5, 0, 0, '0, "R1");

      step(0, 0, 0, 8'h22, "R2");     // edges on 1 and 5
      step(0, 0, 0, 8'h00, "R2");     // drop, still pending
      step(0, 1, 32'hFF, 8'h00, "R3"); // write to pending ignored
      step(0, 0, 0, 8'h00, "R3");

      step(2, 1, 32'h20, 8'h00, "R5");
      step(0, 0, 0, 8'h00, "R3");     // raw bits regardless of enable
      step(6, 0, 0, 8'h00, "R10");    // vector 5
      step(5, 1, 32'h1, 8'h00, "R8"); // half gate
      step(5, 0, 0, 8'h00, "R8");
      step(5, 1, 32'h3, 8'h00, "R8");
      step(6, 0, 0, 8'h00, "R9");     // line rises one edge later
      step(6, 0, 0, 8'h00, "R9");

      step(3, 1, 32'h02, 8'h00, "R6");
      step(3, 0, 0, 8'h00, "R6");     // reads zero
      step(6, 0, 0, 8'h00, "R10");    // vector 1
      step(4, 1, 32'h20, 8'h00, "R7");
      step(4, 0, 0, 8'h00, "R7");
      step(2, 0, 0, 8'h00, "R7");     // only bit 1 left

      step(1, 1, 32'h02, 8'h00, "R4");
      step(1, 0, 0, 8'h00, "R4");     // reads zero
      step(6, 0, 0, 8'h00, "R10");    // nothing qualifies
      step(0, 0, 0, 8'h00, "R4");

      step(1, 1, 32'h08, 8'h08, "R11"); // edge and ack together
      step(0, 0, 0, 8'h08, "R11");
      step(1, 1, 32'h08, 8'h08, "R2");  // held level, ack clears
      step(0, 0, 0, 8'h08, "R2");

      step(2, 1, 32'h0, 8'h00, "R5");   // all disabled
      step(6, 0, 0, 8'h00, "R5");
      step(7, 1, 32'hFFFF_FFFF, 8'h00, "R12");
      step(7, 0, 0, 8'h00, "R12");
      step(2, 0, 0, 8'h00, "R12");
      step(1, 1, 32'hFFFF_FFFF, 8'h00, "R4");
      step(0, 0, 0, 8'h00, "R4");

      for (int k = 0; k < 400; k++) begin
         step(int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)),
              $urandom(), N'($urandom()), "R9");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule